// File: doc/BRIEF.md
# Table-Walk Pointer Cache

This block is a small fully associative store for non-leaf translation results: the pointer that a first-level descriptor gives to a second-level table. A page table walker presents a virtual address and the current address-space identifier (ASID). One cycle later it receives a hit flag and the second-level table base, which lets it skip the first-level memory read.

When the walker completes a first-level fetch it writes the result back through the fill port. The fill is tagged with the ASID that was current at fetch time. That ASID may be the reserved value an operating system uses during a context switch, and the fill may come from a speculative walk; the block stores it like any other entry. Three maintenance requests keep the cache coherent with page table edits. The first removes every entry. The second removes every entry of one ASID. The third removes the entries of one ASID whose 1 MB region overlaps a VA range. Software must use one of them whenever a table entry at any walk level changes.

Each entry holds a valid flag, an 8-bit ASID, the 1 MB region index VA[31:20] and a table base for address bits [31:10]. There are eight entries by default.

Top module: `walk_ptr_cache`

## Requirements
- R1: While reset is high, and after it is released, every entry is invalid and `rsp_valid` is 0.
- R2: `rsp_valid` equals `lk_valid` of the previous cycle. `rsp_hit` is 1 when a valid entry has an ASID equal to `lk_asid` and a region equal to `lk_va[31:20]`. On a hit, `rsp_base` carries that entry's table base.
- R3: A lookup whose ASID differs from the tag of every entry of the same region misses, and on a miss `rsp_base` is 0.
- R4: A fill writes ASID, region `fill_va[31:20]` and base. If a valid entry already holds the same ASID and region, that entry is overwritten in place, so a later lookup returns the newer base.
- R5: A fill that matches no entry takes the lowest-numbered invalid entry. When every entry is valid it takes the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such eviction.
- R6: `inv_all` clears every entry in one cycle, and a fill in the same cycle is dropped.
- R7: `inv_asid_req` with `inv_use_range` = 0 clears every entry whose ASID equals `inv_asid`, and no other entry.
- R8: `inv_asid_req` with `inv_use_range` = 1 clears the entries whose ASID equals `inv_asid` and whose region lies within `inv_lo[31:20]` to `inv_hi[31:20]` inclusive. Entries with another ASID or outside that range stay.
- R9: When an invalidate and a fill arrive in the same cycle, the invalidate is applied first. The fill is dropped if its ASID and region match the invalidate; otherwise it is stored.
- R10: The reserved ASID value 0 is cached and invalidated like any other value. After an invalidate covering it, a lookup with ASID 0 misses until a new fill arrives.
- R11: A lookup is judged against the contents before any fill or invalidate of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 8 | Lookup ASID |
| lk_va | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Registered lookup response valid |
| rsp_hit | output | 1 | Registered hit flag |
| rsp_base | output | 22 | Second-level table base, address bits [31:10] |
| fill_valid | input | 1 | Fill request from the walker |
| fill_asid | input | 8 | ASID current at fetch time |
| fill_va | input | 32 | Virtual address of the walk |
| fill_base | input | 22 | Table base from the first-level descriptor |
| inv_all | input | 1 | Invalidate every entry |
| inv_asid_req | input | 1 | Invalidate by ASID |
| inv_use_range | input | 1 | Restrict the ASID invalidate to a VA range |
| inv_asid | input | 8 | ASID to invalidate |
| inv_lo | input | 32 | Lowest VA of the range |
| inv_hi | input | 32 | Highest VA of the range |

## Verification
The assertions rely on three properties of the inputs:
- Inputs are known after reset.
- In a range invalidate, the region of `inv_lo` is not above that of `inv_hi`.
- Entry uniqueness is never broken from outside, since only fills create entries.

The random stimulus draws its range bounds and swaps them when they come out reversed. It uses four ASIDs, ASID 0 among them, and eight regions, so that hits, in-place refills, evictions and overlapping invalidates occur often. Directed cases add same-cycle fill and invalidate pairs and lookups that coincide with fills.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    localparam int VA_W     = 32;
    localparam int ASID_W   = 8;
    localparam int RGN_LSB  = 20;
    localparam int RGN_W    = VA_W - RGN_LSB;
    localparam int BASE_LSB = 10;
    localparam int BASE_W   = VA_W - BASE_LSB;
    localparam int N_ENT    = 8;

    typedef logic [ASID_W-1:0] asid_t;
    typedef logic [RGN_W-1:0]  rgn_t;
    typedef logic [BASE_W-1:0] base_t;

    typedef struct packed {
        asid_t asid;
        rgn_t  rgn;
        base_t base;
    } ptr_ent_t;

    function automatic rgn_t rgn_of(input logic [VA_W-1:0] va);
        return va[VA_W-1:RGN_LSB];
    endfunction

    function automatic logic rgn_within(input rgn_t r, input rgn_t lo, input rgn_t hi);
        return (r >= lo) && (r <= hi);
    endfunction
endpackage

// File: rtl/wpc_match.sv
module wpc_match
    import wpc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] vld,
    input  ptr_ent_t     ents [N],
    input  asid_t        asid,
    input  rgn_t         rgn,
    output logic [N-1:0] hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = vld[i] && (ents[i].asid == asid) && (ents[i].rgn == rgn);
    end
endmodule

// File: rtl/wpc_kill.sv
module wpc_kill
    import wpc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] vld,
    input  ptr_ent_t     ents [N],
    input  logic         inv_all,
    input  logic         inv_asid_req,
    input  logic         inv_use_range,
    input  asid_t        inv_asid,
    input  rgn_t         lo_rgn,
    input  rgn_t         hi_rgn,
    output logic [N-1:0] kill
);
    for (genvar i = 0; i < N; i++) begin : g_kill
        logic sel;
        assign sel = inv_asid_req && (ents[i].asid == inv_asid) &&
                     (!inv_use_range || rgn_within(ents[i].rgn, lo_rgn, hi_rgn));
        assign kill[i] = vld[i] && (inv_all || sel);
    end
endmodule

// File: rtl/wpc_victim.sv
module wpc_victim #(
    parameter int N     = 8,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]  free,
    input  logic [IW-1:0] rr,
    output logic [IW-1:0] idx,
    output logic          have_free
);
    always_comb begin
        idx       = rr;
        have_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free[i]) begin
                idx       = IW'(i);
                have_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/walk_ptr_cache.sv
module walk_ptr_cache
    import wpc_pkg::*;
#(
    parameter int N_ENTRIES = wpc_pkg::N_ENT,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [BASE_W-1:0] rsp_base,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [BASE_W-1:0] fill_base,
    input  logic              inv_all,
    input  logic              inv_asid_req,
    input  logic              inv_use_range,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VA_W-1:0]   inv_lo,
    input  logic [VA_W-1:0]   inv_hi
);
    ptr_ent_t             ent_q [N_ENTRIES];
    logic [N_ENTRIES-1:0] vld_q;
    logic [IDX_W-1:0]     rr_q;

    logic [N_ENTRIES-1:0] lk_hit, kill, vld_left, fill_hit;
    logic [N_ENTRIES-1:0] vld_nx;
    logic [IDX_W-1:0]     free_idx, wr_idx;
    logic                 have_free, fill_drop, fill_go, evict;
    base_t                hit_base;
    ptr_ent_t             fill_ent;

    // Lookup against the pre-update contents (R11)
    wpc_match #(.N(N_ENTRIES)) u_lk_match (
        .vld(vld_q), .ents(ent_q), .asid(lk_asid), .rgn(rgn_of(lk_va)), .hit(lk_hit)
    );

    wpc_kill #(.N(N_ENTRIES)) u_kill (
        .vld(vld_q), .ents(ent_q), .inv_all(inv_all), .inv_asid_req(inv_asid_req),
        .inv_use_range(inv_use_range), .inv_asid(inv_asid),
        .lo_rgn(rgn_of(inv_lo)), .hi_rgn(rgn_of(inv_hi)), .kill(kill)
    );

    assign vld_left = vld_q & ~kill;

    // Existing-entry search after the invalidate is applied (R4, R9)
    wpc_match #(.N(N_ENTRIES)) u_fill_match (
        .vld(vld_left), .ents(ent_q), .asid(fill_asid), .rgn(rgn_of(fill_va)), .hit(fill_hit)
    );

    wpc_victim #(.N(N_ENTRIES)) u_victim (
        .free(~vld_left), .rr(rr_q), .idx(free_idx), .have_free(have_free)
    );

    assign fill_drop = inv_all ||
                       (inv_asid_req && (fill_asid == inv_asid) &&
                        (!inv_use_range ||
                         rgn_within(rgn_of(fill_va), rgn_of(inv_lo), rgn_of(inv_hi))));
    assign fill_go  = fill_valid && !fill_drop;
    assign evict    = fill_go && !(|fill_hit) && !have_free;
    assign fill_ent = '{asid: fill_asid, rgn: rgn_of(fill_va), base: fill_base};

    always_comb begin
        wr_idx = free_idx;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (fill_hit[i]) wr_idx = IDX_W'(i);
        end
        vld_nx = vld_left;
        if (fill_go) vld_nx[wr_idx] = 1'b1;
    end

    always_comb begin
        hit_base = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (lk_hit[i]) hit_base = hit_base | ent_q[i].base;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            rr_q  <= '0;
            for (int i = 0; i < N_ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            vld_q <= vld_nx;
            if (fill_go) ent_q[wr_idx] <= fill_ent;
            if (evict) rr_q <= (rr_q == IDX_W'(N_ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_base  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && (|lk_hit);
            rsp_base  <= (lk_valid && (|lk_hit)) ? hit_base : '0;
        end
    end
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker
    import wpc_pkg::*;
#(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         lk_valid,
    input logic         rsp_valid,
    input logic         rsp_hit,
    input base_t        rsp_base,
    input logic         inv_all,
    input logic         inv_asid_req,
    input logic         inv_use_range,
    input asid_t        inv_asid,
    input logic [N-1:0] vld_q,
    input ptr_ent_t     ent_q [N],
    input logic [N-1:0] lk_hit
);
    asid_t prev_asid;
    logic  leftover;

    always_ff @(posedge clk) prev_asid <= inv_asid;

    always_comb begin
        leftover = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (vld_q[i] && ent_q[i].asid == prev_asid) leftover = 1'b1;
        end
    end

    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (!rsp_valid && vld_q == '0));

    p_single_hit_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit));

    p_rsp_on_lookup_r2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!rsp_valid && !rsp_hit));

    p_miss_base_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_base == '0));

    p_flush_all_r6: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (vld_q == '0));

    p_asid_flush_r7: assert property (@(posedge clk) disable iff (rst)
        (inv_asid_req && !inv_use_range) |=> !leftover);
endmodule

bind walk_ptr_cache wpc_checker #(.N(N_ENTRIES)) u_wpc_checker (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_base(rsp_base), .inv_all(inv_all),
    .inv_asid_req(inv_asid_req), .inv_use_range(inv_use_range),
    .inv_asid(inv_asid), .vld_q(vld_q), .ent_q(ent_q), .lk_hit(lk_hit)
);

// File: tb/walk_ptr_cache_bench.sv
module walk_ptr_cache_bench;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 0, fill_valid = 0, inv_all = 0, inv_asid_req = 0, inv_use_range = 0;
    logic [7:0]  lk_asid = 0, fill_asid = 0, inv_asid = 0;
    logic [31:0] lk_va = 0, fill_va = 0, inv_lo = 0, inv_hi = 0;
    logic [21:0] fill_base = 0;
    logic        rsp_valid, rsp_hit;
    logic [21:0] rsp_base;

    int tests = 0, fails = 0;
    bit done = 0;

    // reference array
    bit          m_v [N];
    logic [7:0]  m_a [N];
    logic [11:0] m_r [N];
    logic [21:0] m_b [N];
    int          m_rr;

    always #5 clk = ~clk;

    walk_ptr_cache u_walk_ptr_cache (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_va(lk_va),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_base(rsp_base),
        .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_va(fill_va), .fill_base(fill_base),
        .inv_all(inv_all), .inv_asid_req(inv_asid_req), .inv_use_range(inv_use_range),
        .inv_asid(inv_asid), .inv_lo(inv_lo), .inv_hi(inv_hi)
    );

    function automatic bit inv_hits(input logic [7:0] a, input logic [11:0] r);
        return inv_all || (inv_asid_req && a == inv_asid &&
               (!inv_use_range || (r >= inv_lo[31:20] && r <= inv_hi[31:20])));
    endfunction

    function automatic logic [11:0] va_r(input logic [11:0] r);
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: model the cycle, then compare outputs after the edge
    task automatic cyc(input string tag);
        bit          e_hit = 0;
        logic [21:0] e_base = '0;
        bit          e_v = lk_valid;
        int          j = -1;
        if (lk_valid)
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_a[i] == lk_asid && m_r[i] == lk_va[31:20]) begin
                    e_hit = 1; e_base = m_b[i];
                end
        for (int i = 0; i < N; i++)
            if (m_v[i] && inv_hits(m_a[i], m_r[i])) m_v[i] = 0;
        if (fill_valid && !inv_hits(fill_asid, fill_va[31:20])) begin
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_a[i] == fill_asid && m_r[i] == fill_va[31:20]) j = i;
            if (j < 0)
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) j = i;
            if (j < 0) begin
                j = m_rr; m_rr = (m_rr + 1) % N;
            end
            m_v[j] = 1; m_a[j] = fill_asid; m_r[j] = fill_va[31:20]; m_b[j] = fill_base;
        end
        @(negedge clk);
        check({tag, " rsp_valid"}, 32'(rsp_valid), 32'(e_v));
        if (e_v) begin
            check({tag, " hit"}, 32'(rsp_hit), 32'(e_hit));
            check({tag, " base"}, 32'(rsp_base), 32'(e_base));
        end
        lk_valid = 0; fill_valid = 0; inv_all = 0; inv_asid_req = 0; inv_use_range = 0;
    endtask

    task automatic look(input logic [7:0] a, input logic [11:0] r, input string tag);
        lk_valid = 1; lk_asid = a; lk_va = {r, 20'h5A5A5};
        cyc(tag);
    endtask

    task automatic fill(input logic [7:0] a, input logic [11:0] r, input logic [21:0] b);
        fill_valid = 1; fill_asid = a; fill_va = {r, 20'h00123}; fill_base = b;
    endtask

    task automatic rinv(input logic [7:0] a, input logic [11:0] lo, input logic [11:0] hi);
        inv_asid_req = 1; inv_use_range = 1; inv_asid = a;
        inv_lo = {lo, 20'h0}; inv_hi = {hi, 20'hFFFFF};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_rr = 0;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", 32'(rsp_valid), 0);
        rst = 0;
        look(8'd1, 12'h003, "R1 empty after reset");

        // R2 fill then hit
        fill(8'd1, 12'h003, 22'h1ABCD); cyc("R4 fill");
        look(8'd1, 12'h003, "R2 hit");
        // R3 ASID mismatch
        look(8'd2, 12'h003, "R3 asid mismatch");
        // R4 overwrite in place
        fill(8'd1, 12'h003, 22'h00777); cyc("R4 refill");
        look(8'd1, 12'h003, "R4 newer base");
        // R11 lookup coinciding with fill
        fill(8'd1, 12'h009, 22'h00999); lk_valid = 1; lk_asid = 1; lk_va = 32'h0090_0000;
        cyc("R11 same-cycle miss");
        look(8'd1, 12'h009, "R11 later hit");

        // R5 allocation and round robin
        inv_all = 1; cyc("R6 flush");
        look(8'd1, 12'h003, "R6 cleared");
        for (int i = 0; i < 8; i++) begin fill(8'd3, 12'(i), 22'(i + 16)); cyc("R5 fill"); end
        fill(8'd3, 12'h008, 22'h00088); cyc("R5 evict");
        look(8'd3, 12'h000, "R5 first evicted");
        look(8'd3, 12'h001, "R5 second kept");
        look(8'd3, 12'h008, "R5 new present");
        fill(8'd3, 12'h00A, 22'h000AA); cyc("R5 evict 2");
        look(8'd3, 12'h001, "R5 pointer advanced");
        look(8'd3, 12'h002, "R5 third kept");

        // R8 range invalidate
        inv_all = 1; cyc("R6 flush");
        for (int i = 16; i < 21; i++) begin fill(8'd5, 12'(i), 22'(i)); cyc("R8 fill"); end
        fill(8'd6, 12'h012, 22'h00612); cyc("R8 fill other asid");
        rinv(8'd5, 12'h012, 12'h013); cyc("R8 range inv");
        look(8'd5, 12'h011, "R8 below range kept");
        look(8'd5, 12'h012, "R8 lo removed");
        look(8'd5, 12'h013, "R8 hi removed");
        look(8'd5, 12'h014, "R8 above range kept");
        look(8'd6, 12'h012, "R8 other asid kept");
        // R7 asid-only invalidate
        inv_asid_req = 1; inv_asid = 8'd5; cyc("R7 asid inv");
        look(8'd5, 12'h014, "R7 removed");
        look(8'd6, 12'h012, "R7 other asid kept");

        // R9 invalidate with concurrent fill
        fill(8'd6, 12'h030, 22'h00300); rinv(8'd6, 12'h030, 12'h030); cyc("R9 drop");
        look(8'd6, 12'h030, "R9 fill dropped");
        fill(8'd6, 12'h031, 22'h00310); rinv(8'd6, 12'h030, 12'h030); cyc("R9 keep");
        look(8'd6, 12'h031, "R9 fill kept");
        fill(8'd7, 12'h032, 22'h00320); inv_all = 1; cyc("R6 drop fill");
        look(8'd7, 12'h032, "R6 fill dropped");

        // R10 reserved ASID reuse after invalidation
        fill(8'd0, 12'h005, 22'h0DEAD); cyc("R10 fill");
        look(8'd0, 12'h005, "R10 cached");
        rinv(8'd0, 12'h004, 12'h006); cyc("R10 inv");
        look(8'd0, 12'h005, "R10 stale gone");
        fill(8'd0, 12'h005, 22'h0BEEF); cyc("R10 refill");
        look(8'd0, 12'h005, "R10 new pointer");

        // random traffic
        void'($urandom(32'd2024));
        for (int n = 0; n < 4000; n++) begin
            int p = $urandom % 100;
            lk_valid = ($urandom % 10) < 7;
            lk_asid = 8'($urandom % 4); lk_va = {12'($urandom % 8), 20'($urandom)};
            if (($urandom % 10) < 3) fill(8'($urandom % 4), 12'($urandom % 8), 22'($urandom));
            if (p < 5) begin
                logic [11:0] a = 12'($urandom % 8), b = 12'($urandom % 8);
                if (a > b) rinv(8'($urandom % 4), b, a); else rinv(8'($urandom % 4), a, b);
            end else if (p < 8) begin
                inv_asid_req = 1; inv_asid = 8'($urandom % 4);
            end else if (p < 9) inv_all = 1;
            cyc("R2 R4 R5 R7 R8 R9 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule